// File: doc/BRIEF.md
# Open-Row DRAM Access Sequencer

This block turns single-word read and write requests into the row and column commands of a banked DRAM-style array. Each request address is split into bank, row and column fields. A small table holds the open row of every bank. When a request falls on the row already open in its bank, the block sends only the column command. When the bank has a different row open, the block closes it with a precharge, opens the new row with an activate, and then sends the column command. When the bank has no open row, the precharge is skipped. Rows stay open after the access, so later accesses to the same row skip activation.

Three programmable gaps are held on plain control pins:
- activate to column command;
- precharge to activate;
- read command to the cycle in which the array's read data is valid.

Requests arrive on a valid/ready port. Read results leave on a valid/ready port and come back in request order. Only one request is in flight at a time. `req_ready` is high only while the sequencer is idle. A read result stays on `rsp_valid`/`rsp_data`, unchanged, until `rsp_ready` is seen. No new request is taken while a result waits.

Top module: `dram_row_seq`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, `cmd_op` is 0 (no command), and every bank is treated as closed.
- R2: The request address is split as follows, and those fields appear on `cmd_bank`, `cmd_row` and `cmd_col`:
  - column = `req_addr[2:0]`;
  - row = `req_addr[6:3]`;
  - bank = `req_addr[8:7]`.
- R3: `cmd_op` codes are 1 activate, 2 read, 3 write and 4 precharge. An access to a bank with no open row issues an activate and then the column command, with no precharge.
- R4: An access to the row already open in its bank issues only its column command, in the cycle after acceptance. Back-to-back hits therefore form a burst of column commands with no row command between them.
- R5: An access to a bank holding a different open row issues precharge, then activate, then the column command. A column command is never sent to a bank whose open row differs from the addressed one.
- R6: The column command follows its activate by exactly `t_rcd` cycles. A setting of 0 acts as 1.
- R7: The activate follows its precharge by exactly `t_rp` cycles. A setting of 0 acts as 1.
- R8: Read data is taken from `arr_rdata` exactly `t_rl` cycles after the read command (0 acts as 1). `rsp_valid` rises one cycle after that.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high, `rsp_data` stays unchanged and `req_ready` stays low.
- R10: Opening a row in one bank leaves the open rows of all other banks unchanged.
- R11: A write sends `req_wdata` on `cmd_wdata` with its write command. A later read of the same address returns that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t_rcd | input | 4 | Activate to column command gap, cycles |
| t_rp | input | 4 | Precharge to activate gap, cycles |
| t_rl | input | 4 | Read command to array data valid, cycles |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | 9 | Word address: bank, row, column |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read result valid |
| rsp_ready | input | 1 | Read result taken when high with `rsp_valid` |
| rsp_data | output | 16 | Read result |
| cmd_op | output | 3 | Array command code (R3) |
| cmd_bank | output | 2 | Command bank |
| cmd_row | output | 4 | Command row (meaningful with activate) |
| cmd_col | output | 3 | Command column (meaningful with read/write) |
| cmd_wdata | output | 16 | Data sent with a write command |
| arr_rdata | input | 16 | Array read data, valid `t_rl` cycles after a read |

## Verification
The open-row table and the gap counter are the two pieces of state whose errors can reach the pins.
- **Stale table entry.** The request that addresses the affected bank shows it on the command pins within a few cycles. It appears as a missing precharge, a spurious activate, or a column command aimed at a row that is not open.
- **Wrong gap count.** It shows as a command spacing that differs from the programmed value.
- **Wrong read latency.** The array model drives a marker word outside the one valid cycle, so an off-by-one capture returns that marker on `rsp_data` in the same request.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4
  } cmd_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE,
    S_W_RP,
    S_ACT,
    S_W_RCD,
    S_COL,
    S_W_RL,
    S_CAP,
    S_RSP
  } seq_st_e;

endpackage

// File: rtl/dram_open_rows.sv
module dram_open_rows #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] q_bank,
  input  logic [ROW_W-1:0]  q_row,
  output logic              q_open,
  output logic              q_hit,
  input  logic              set_en,
  input  logic [BANK_W-1:0] set_bank,
  input  logic [ROW_W-1:0]  set_row,
  input  logic              clr_en,
  input  logic [BANK_W-1:0] clr_bank
);
  localparam int NBANK = 1 << BANK_W;

  logic [NBANK-1:0] open_vec;
  logic [ROW_W-1:0] row_arr [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             vld_q;
    logic [ROW_W-1:0] row_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        row_q <= '0;
      end else if (set_en && set_bank == BANK_W'(b)) begin
        vld_q <= 1'b1;
        row_q <= set_row;
      end else if (clr_en && clr_bank == BANK_W'(b)) begin
        vld_q <= 1'b0;
      end
    end
    assign open_vec[b] = vld_q;
    assign row_arr[b]  = row_q;
  end

  assign q_open = open_vec[q_bank];
  assign q_hit  = q_open && (row_arr[q_bank] == q_row);

  // R5: a row is only opened in a bank that was closed first
  p_act_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !open_vec[set_bank]);

  // R10: opening a row never closes another bank
  p_other_banks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> ($countones(open_vec) >= $countones($past(open_vec))));

endmodule

// File: rtl/dram_gap_timer.sv
module dram_gap_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          short_len,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= (len == '0) ? '0 : len - TW'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - TW'(1);
  end

  assign short_len = (len <= TW'(1));
  assign expired   = (cnt_q <= TW'(1));

  // the countdown never moves upward unless reloaded
  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) && $past(rst_n) |-> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/dram_row_seq.sv
module dram_row_seq
  import dram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 3,
  parameter int DW     = 16,
  parameter int TW     = 4,
  localparam int AW    = BANK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     t_rcd,
  input  logic [TW-1:0]     t_rp,
  input  logic [TW-1:0]     t_rl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_data,
  output logic [2:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic [DW-1:0]     cmd_wdata,
  input  logic [DW-1:0]     arr_rdata
);
  localparam int SW = TW + 1;

  seq_st_e st_q, st_d;

  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [DW-1:0]     wdata_q;
  logic [DW-1:0]     rdata_q;

  logic [BANK_W-1:0] in_bank;
  logic [ROW_W-1:0]  in_row;
  logic [COL_W-1:0]  in_col;
  assign in_col  = req_addr[COL_W-1:0];
  assign in_row  = req_addr[COL_W +: ROW_W];
  assign in_bank = req_addr[AW-1 -: BANK_W];

  logic accept;
  assign req_ready = (st_q == S_IDLE);
  assign accept    = req_valid && req_ready;

  // open-row lookup: the incoming address while idle, the held one after
  logic [BANK_W-1:0] q_bank;
  logic [ROW_W-1:0]  q_row;
  logic              q_open, q_hit;
  assign q_bank = (st_q == S_IDLE) ? in_bank : bank_q;
  assign q_row  = (st_q == S_IDLE) ? in_row  : row_q;

  dram_open_rows #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_bank   (q_bank),
    .q_row    (q_row),
    .q_open   (q_open),
    .q_hit    (q_hit),
    .set_en   (st_q == S_ACT),
    .set_bank (bank_q),
    .set_row  (row_q),
    .clr_en   (st_q == S_PRE),
    .clr_bank (bank_q)
  );

  // one shared gap counter: only one wait is ever pending
  logic          tmr_load, tmr_short, tmr_done;
  logic [TW-1:0] tmr_len;
  always_comb begin
    unique case (st_q)
      S_PRE:   tmr_len = t_rp;
      S_ACT:   tmr_len = t_rcd;
      default: tmr_len = t_rl;
    endcase
  end
  assign tmr_load = (st_q == S_PRE) || (st_q == S_ACT) || (st_q == S_COL && !we_q);

  dram_gap_timer #(.TW(TW)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tmr_load),
    .len       (tmr_len),
    .short_len (tmr_short),
    .expired   (tmr_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (accept) st_d = q_hit ? S_COL : (q_open ? S_PRE : S_ACT);
      S_PRE:   st_d = tmr_short ? S_ACT : S_W_RP;
      S_W_RP:  if (tmr_done) st_d = S_ACT;
      S_ACT:   st_d = tmr_short ? S_COL : S_W_RCD;
      S_W_RCD: if (tmr_done) st_d = S_COL;
      S_COL:   st_d = we_q ? S_IDLE : (tmr_short ? S_CAP : S_W_RL);
      S_W_RL:  if (tmr_done) st_d = S_CAP;
      S_CAP:   st_d = S_RSP;
      S_RSP:   if (rsp_ready) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        bank_q  <= in_bank;
        row_q   <= in_row;
        col_q   <= in_col;
        we_q    <= req_we;
        wdata_q <= req_wdata;
      end
      if (st_q == S_CAP) rdata_q <= arr_rdata;
    end
  end

  cmd_e cmd;
  always_comb begin
    unique case (st_q)
      S_PRE:   cmd = CMD_PRE;
      S_ACT:   cmd = CMD_ACT;
      S_COL:   cmd = we_q ? CMD_WR : CMD_RD;
      default: cmd = CMD_NONE;
    endcase
  end

  assign cmd_op    = cmd;
  assign cmd_bank  = bank_q;
  assign cmd_row   = row_q;
  assign cmd_col   = col_q;
  assign cmd_wdata = wdata_q;
  assign rsp_valid = (st_q == S_RSP);
  assign rsp_data  = rdata_q;

  // ---------------- checking counters and assertions ----------------
  function automatic logic [SW-1:0] eff_gap(input logic [TW-1:0] x);
    return (x == '0) ? SW'(1) : {1'b0, x};
  endfunction

  logic [SW-1:0] since_act, since_pre, since_rd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '1;
      since_pre <= '1;
      since_rd  <= '1;
    end else begin
      since_act <= (cmd == CMD_ACT) ? SW'(1) : ((since_act == '1) ? since_act : since_act + SW'(1));
      since_pre <= (cmd == CMD_PRE) ? SW'(1) : ((since_pre == '1) ? since_pre : since_pre + SW'(1));
      since_rd  <= (cmd == CMD_RD)  ? SW'(1) : ((since_rd  == '1) ? since_rd  : since_rd  + SW'(1));
    end
  end

  p_col_open_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> q_hit);

  p_act_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> since_act >= eff_gap(t_rcd));

  p_pre_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |-> since_pre >= eff_gap(t_rp));

  p_read_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CAP) |-> since_rd == eff_gap(t_rl));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

endmodule

// File: tb/tb_dram_row_seq.sv
module tb_dram_row_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]  t_rcd = 4'd3, t_rp = 4'd2, t_rl = 4'd2;
  logic        req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1;
  logic [8:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_data, cmd_wdata, arr_rdata;
  logic [2:0]  cmd_op;
  logic [1:0]  cmd_bank;
  logic [3:0]  cmd_row;
  logic [2:0]  cmd_col;

  dram_row_seq dut (
    .clk(clk), .rst_n(rst_n), .t_rcd(t_rcd), .t_rp(t_rp), .t_rl(t_rl),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .cmd_wdata(cmd_wdata), .arr_rdata(arr_rdata)
  );

  int checks = 0, errors = 0;
  int cyc = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] init_val(input int i);
    return 16'h5A00 ^ 16'(i);
  endfunction

  function automatic int eff(input logic [3:0] x);
    return (x == 0) ? 1 : int'(x);
  endfunction

  // ---------------- array model with legality checks ----------------
  logic [15:0] mem [512];
  logic        bopen [4];
  logic [3:0]  brow  [4];
  logic [15:0] rd_word;
  int          rd_cd = 0;
  int          m_checks = 0, m_errors = 0;

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = init_val(i);
    for (int b = 0; b < 4; b++) begin bopen[b] = 1'b0; brow[b] = '0; end
  end

  assign arr_rdata = (rd_cd == 1) ? rd_word : 16'hDEAD;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_cd > 0) rd_cd <= rd_cd - 1;
    if (rst_n) begin
      case (cmd_op)
        3'd1: begin
          m_checks <= m_checks + 1;
          if (bopen[cmd_bank]) begin
            m_errors <= m_errors + 1;
            $display("FAIL R5 activate to open bank actual=%0d expected=0", cmd_bank);
          end
          bopen[cmd_bank] <= 1'b1;
          brow[cmd_bank]  <= cmd_row;
        end
        3'd4: bopen[cmd_bank] <= 1'b0;
        3'd2, 3'd3: begin
          m_checks <= m_checks + 1;
          if (!bopen[cmd_bank]) begin
            m_errors <= m_errors + 1;
            $display("FAIL R5 column command to closed bank actual=0 expected=1");
          end
          if (cmd_op == 3'd3) mem[{cmd_bank, brow[cmd_bank], cmd_col}] <= cmd_wdata;
          else begin
            rd_word <= mem[{cmd_bank, brow[cmd_bank], cmd_col}];
            rd_cd   <= eff(t_rl);
          end
        end
        default: ;
      endcase
    end
  end

  // ---------------- command log ----------------
  int log_n = 0;
  int log_cyc [32];
  int log_cmd [32];
  int log_bank[32];
  int log_row [32];
  int log_col [32];

  always @(negedge clk) begin
    if (rst_n && cmd_op != 3'd0 && log_n < 32) begin
      log_cyc[log_n]  = cyc;
      log_cmd[log_n]  = int'(cmd_op);
      log_bank[log_n] = int'(cmd_bank);
      log_row[log_n]  = int'(cmd_row);
      log_col[log_n]  = int'(cmd_col);
      log_n = log_n + 1;
    end
  end

  int acc_cyc, rsp_cyc;
  logic [15:0] got;

  task automatic access(input logic [8:0] a, input logic we, input logic [15:0] wd,
                        input int hold);
    @(negedge clk);
    log_n = 0;
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd;
    rsp_ready = (hold == 0);
    while (!req_ready) @(negedge clk);
    acc_cyc = cyc;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (!we) begin
      @(negedge clk);
      while (!rsp_valid) @(negedge clk);
      rsp_cyc = cyc;
      got = rsp_data;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk("R9 valid held", rsp_valid, 1'b1);
        chk("R9 data stable", rsp_data, got);
        chk("R9 no accept while busy", req_ready, 1'b0);
      end
      rsp_ready = 1'b1;
      @(posedge clk); #1;
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 req_ready", req_ready, 1'b1);
    chk("R1 rsp_valid", rsp_valid, 1'b0);
    chk("R1 cmd none", cmd_op, 3'd0);
  endtask

  task automatic t_cold_write;
    access({2'd0, 4'd3, 3'd1}, 1'b1, 16'h1111, 0);
    chk("R3 two commands", log_n, 2);
    chk("R3 first is activate", log_cmd[0], 1);
    chk("R2 activate row", log_row[0], 3);
    chk("R3 activate right after accept", log_cyc[0], acc_cyc + 1);
    chk("R3 then write", log_cmd[1], 3);
    chk("R2 write column", log_col[1], 1);
    chk("R6 rcd gap", log_cyc[1] - log_cyc[0], eff(t_rcd));
  endtask

  task automatic t_hit_burst;
    access({2'd0, 4'd3, 3'd2}, 1'b1, 16'h2222, 0);
    chk("R4 single command", log_n, 1);
    chk("R4 write only", log_cmd[0], 3);
    chk("R4 next cycle", log_cyc[0], acc_cyc + 1);
    access({2'd0, 4'd3, 3'd5}, 1'b1, 16'h5555, 0);
    chk("R4 burst hit single", log_n, 1);
    access({2'd0, 4'd3, 3'd1}, 1'b0, '0, 0);
    chk("R4 read hit single", log_cmd[0], 2);
    chk("R11 readback", got, 16'h1111);
    chk("R8 rsp cycle", rsp_cyc, log_cyc[0] + eff(t_rl) + 1);
  endtask

  task automatic t_miss;
    access({2'd0, 4'd5, 3'd0}, 1'b0, '0, 0);
    chk("R5 three commands", log_n, 3);
    chk("R5 precharge first", log_cmd[0], 4);
    chk("R5 activate second", log_cmd[1], 1);
    chk("R5 activate row", log_row[1], 5);
    chk("R5 read third", log_cmd[2], 2);
    chk("R7 rp gap", log_cyc[1] - log_cyc[0], eff(t_rp));
    chk("R6 rcd gap after miss", log_cyc[2] - log_cyc[1], eff(t_rcd));
    chk("R8 miss data", got, init_val({2'd0, 4'd5, 3'd0}));
  endtask

  task automatic t_banks;
    access({2'd1, 4'd9, 3'd3}, 1'b1, 16'hB1B1, 0);
    chk("R10 other bank cold", log_cmd[0], 1);
    access({2'd0, 4'd5, 3'd0}, 1'b0, '0, 0);
    chk("R10 bank0 still open", log_n, 1);
    chk("R10 bank0 data", got, init_val({2'd0, 4'd5, 3'd0}));
    access({2'd1, 4'd9, 3'd3}, 1'b0, '0, 0);
    chk("R10 bank1 hit", log_n, 1);
    chk("R11 bank1 data", got, 16'hB1B1);
  endtask

  task automatic t_latency(input logic [3:0] rl);
    t_rl = rl;
    access({2'd0, 4'd5, 3'd4}, 1'b0, '0, 0);
    chk("R8 latency data", got, init_val({2'd0, 4'd5, 3'd4}));
    chk("R8 latency cycle", rsp_cyc, log_cyc[0] + eff(rl) + 1);
  endtask

  task automatic t_min_gaps;
    t_rcd = 4'd0; t_rp = 4'd1;
    access({2'd0, 4'd7, 3'd6}, 1'b1, 16'h7777, 0);
    chk("R7 min rp gap", log_cyc[1] - log_cyc[0], 1);
    chk("R6 zero rcd acts as one", log_cyc[2] - log_cyc[1], 1);
    t_rcd = 4'd3; t_rp = 4'd2;
  endtask

  task automatic t_backpressure;
    access({2'd0, 4'd7, 3'd6}, 1'b0, '0, 4);
    chk("R9 data after hold", got, 16'h7777);
  endtask

  task automatic t_decode;
    access(9'h1FF, 1'b1, 16'hBEEF, 0);
    chk("R2 bank field", log_bank[0], 3);
    chk("R2 row field", log_row[0], 15);
    chk("R2 col field", log_col[1], 7);
    access(9'h1FF, 1'b0, '0, 0);
    chk("R11 decode readback", got, 16'hBEEF);
  endtask

  task automatic finish_sim;
    $display("  CHECKS %0d ERRORS %0d", checks + m_checks, errors + m_errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_write();
    t_hit_burst();
    t_miss();
    t_banks();
    t_latency(4'd1);
    t_latency(4'd6);
    t_latency(4'd0);
    t_rl = 4'd2;
    t_min_gaps();
    t_backpressure();
    t_decode();
    repeat (3) @(negedge clk);
    finish_sim();
  end

endmodule